// File: doc/BRIEF.md
# Fracturable Six-Input Lookup Table

This block is a configurable logic element holding a 64-bit truth-table mask and one mode bit. In single mode it evaluates one arbitrary function of six inputs by using those inputs as an address into the mask. In split mode the mask is treated as two independent 32-bit tables. Each table drives its own output and is addressed by five inputs. Two of those five inputs are shared by both tables, and each table also has three private inputs, so the two functions together draw on at most eight distinct signals.

The mask and mode bit are written through a single-bit serial shift chain while a program-enable input is high. Any function is realised by shifting in its truth table. For example, a mask with only its highest bit set gives a six-input AND. Outside configuration the outputs are pure combinational functions of the inputs and the stored configuration.

Top module: `frac_lut`

## Requirements
- R1: While reset is asserted, and after it is released, the mode bit and all 64 mask bits are zero and both outputs read 0.
- R2: While `cfg_en` is high, each rising clock edge shifts `cfg_bit` into a 65-bit chain. After 65 edges the first bit sent is the mode bit (0 = single, 1 = split), followed by mask bit 63 down to mask bit 0. While `cfg_en` is low, the chain holds its contents.
- R3: While `cfg_en` is high, both outputs are 0.
- R4: In single mode, `out0` equals mask bit {in_top, in_priv0[2:0], in_shared[1:0]}, where in_top is the MSB and in_shared[0] is the LSB.
- R5: In single mode, `out1` is 0 and `in_priv1` has no effect on either output.
- R6: In split mode, `out0` equals mask bit {in_priv0[2:0], in_shared[1:0]} taken from mask bits 31..0.
- R7: In split mode, `out1` equals mask bit 32 + {in_priv1[2:0], in_shared[1:0]}, taken from mask bits 63..32.
- R8: In split mode, `in_top` has no effect, `out0` does not depend on `in_priv1`, and `out1` does not depend on `in_priv0`.
- R9: Outside configuration, an input change reaches the outputs without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_en | input | 1 | Program enable; shifts the chain and forces the outputs low |
| cfg_bit | input | 1 | Serial configuration data, mode bit first |
| in_shared | input | 2 | Inputs common to both tables |
| in_priv0 | input | 3 | Private inputs of function 0, also used in single mode |
| in_priv1 | input | 3 | Private inputs of function 1, used only in split mode |
| in_top | input | 1 | Half-select input in single mode |
| out0 | output | 1 | Function 0, or the single six-input function |
| out1 | output | 1 | Function 1 in split mode, otherwise 0 |

## Verification
The bench builds the block with its default parameters: six table inputs and two shared inputs. These give a full 64-bit mask and 3-bit private groups, so the single-mode half select and the split-mode isolation of the private groups can both be exercised. Configurations of a six-input AND, a lone mask bit 0, a lone mask bit 32, and a split parity/OR pair place single bits at both ends of each half. Together they show whether the chain ordering, the half boundary and the input-to-address bit order are correct.

// File: rtl/frac_lut_pkg.sv
package frac_lut_pkg;
  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_SPLIT  = 1'b1
  } lut_mode_e;
endpackage

// File: rtl/flut_cfg_chain.sv
module flut_cfg_chain #(
  parameter int W = 65
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] state
);
  logic [W-1:0] state_q;
  logic [W-1:0] state_d;

  always_comb begin
    state_d = state_q;
    if (shift_en) begin
      state_d = {state_q[W-2:0], bit_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (state_q == '0)); // R1
  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (state_q[0] == $past(bit_in))); // R2
  AST_HOLD_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(state_q)); // R2
endmodule

// File: rtl/flut_half_table.sv
module flut_half_table #(
  parameter int ADDR_W = 5
) (
  input  logic [(1<<ADDR_W)-1:0] mask,
  input  logic [ADDR_W-1:0]      addr,
  output logic                   value
);
  assign value = mask[addr];
endmodule

// File: rtl/frac_lut.sv
module frac_lut #(
  parameter int K      = 6,
  parameter int SHARED = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_en,
  input  logic                      cfg_bit,
  input  logic [SHARED-1:0]         in_shared,
  input  logic [K-1-SHARED-1:0]     in_priv0,
  input  logic [K-1-SHARED-1:0]     in_priv1,
  input  logic                      in_top,
  output logic                      out0,
  output logic                      out1
);
  import frac_lut_pkg::*;

  localparam int HALF_IN = K - 1;
  localparam int PRIV    = HALF_IN - SHARED;
  localparam int MASK_W  = 1 << K;
  localparam int HALF_W  = MASK_W / 2;
  localparam int CHAIN_W = MASK_W + 1;

  logic [1:0]         rst_sync_q;
  logic               rst_sync_n;
  logic [CHAIN_W-1:0] cfg_word;
  logic [MASK_W-1:0]  mask;
  lut_mode_e          mode;
  logic [1:0]         half_val;
  logic [PRIV-1:0]    priv_sel [2];

  // Reset: asserted at once, released after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  flut_cfg_chain #(.W(CHAIN_W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .shift_en (cfg_en),
    .bit_in   (cfg_bit),
    .state    (cfg_word)
  );

  assign mask = cfg_word[MASK_W-1:0];
  assign mode = lut_mode_e'(cfg_word[CHAIN_W-1]);

  // The upper half reads the private group of function 0 unless the element is split.
  assign priv_sel[0] = in_priv0;
  assign priv_sel[1] = (mode == MODE_SPLIT) ? in_priv1 : in_priv0;

  for (genvar h = 0; h < 2; h++) begin : g_half
    flut_half_table #(.ADDR_W(HALF_IN)) u_tab (
      .mask  (mask[h*HALF_W +: HALF_W]),
      .addr  ({priv_sel[h], in_shared}),
      .value (half_val[h])
    );
  end

  always_comb begin
    out0 = 1'b0;
    out1 = 1'b0;
    if (!cfg_en) begin
      if (mode == MODE_SPLIT) begin
        out0 = half_val[0];
        out1 = half_val[1];
      end else begin
        out0 = in_top ? half_val[1] : half_val[0];
      end
    end
  end

  AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_en |-> (!out0 && !out1)); // R3
  AST_SINGLE_OUT1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == MODE_SINGLE) |-> !out1); // R5
  AST_SPLIT_ISOL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((mode == MODE_SPLIT) && $stable(cfg_word) && !cfg_en && $past(!cfg_en)
     && $stable(in_shared) && $stable(in_priv0)) |-> $stable(out0)); // R8
endmodule

// File: tb/frac_lut_tb.sv
module frac_lut_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_en;
  logic       cfg_bit;
  logic [1:0] in_shared;
  logic [2:0] in_priv0;
  logic [2:0] in_priv1;
  logic       in_top;
  logic       out0;
  logic       out1;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  frac_lut u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
    .in_shared(in_shared), .in_priv0(in_priv0), .in_priv1(in_priv1),
    .in_top(in_top), .out0(out0), .out1(out1)
  );

  // Configuration words: {mode, mask[63:0]}
  localparam logic [64:0] CFG_AND6  = {1'b0, 64'h8000_0000_0000_0000};
  localparam logic [64:0] CFG_SPLIT = {1'b1, 32'hFFFF_FFFE, 32'h9669_6996};

  // Vector: [11] config (0 AND6, 1 SPLIT) [10:9] shared [8:6] priv0 [5:3] priv1 [2] top [1] exp out0 [0] exp out1
  localparam int NV = 9;
  localparam logic [11:0] VEC [NV] = '{
    {1'b0, 2'b11, 3'b111, 3'b000, 1'b1, 1'b1, 1'b0},
    {1'b0, 2'b11, 3'b111, 3'b000, 1'b0, 1'b0, 1'b0},
    {1'b0, 2'b10, 3'b111, 3'b000, 1'b1, 1'b0, 1'b0},
    {1'b0, 2'b11, 3'b111, 3'b101, 1'b1, 1'b1, 1'b0},
    {1'b1, 2'b00, 3'b000, 3'b000, 1'b0, 1'b0, 1'b0},
    {1'b1, 2'b01, 3'b000, 3'b000, 1'b0, 1'b1, 1'b1},
    {1'b1, 2'b00, 3'b011, 3'b100, 1'b0, 1'b0, 1'b1},
    {1'b1, 2'b11, 3'b111, 3'b000, 1'b0, 1'b1, 1'b1},
    {1'b1, 2'b00, 3'b100, 3'b000, 1'b1, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic got, input logic exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic drive(input logic [1:0] sh, input logic [2:0] p0,
                       input logic [2:0] p1, input logic top);
    in_shared = sh; in_priv0 = p0; in_priv1 = p1; in_top = top;
  endtask

  task automatic load_cfg(input logic [64:0] word, input bit watch);
    @(negedge clk);
    cfg_en = 1'b1;
    for (int i = 64; i >= 0; i--) begin
      cfg_bit = word[i];
      if (watch && i == 32) begin
        #3;
        check("R3 out0 low while programming", out0, 1'b0);
        check("R3 out1 low while programming", out1, 1'b0);
      end
      @(negedge clk);
    end
    cfg_en  = 1'b0;
    cfg_bit = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic cur;
    rst_n = 1'b0; cfg_en = 1'b0; cfg_bit = 1'b0;
    drive(2'b11, 3'b111, 3'b111, 1'b1);
    repeat (3) @(negedge clk);
    #2;
    check("R1 out0 in reset", out0, 1'b0);
    check("R1 out1 in reset", out1, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    check("R1 out0 after reset", out0, 1'b0);
    check("R1 out1 after reset", out1, 1'b0);

    // Table walk: R4 R5 R6 R7 R8; inputs change mid-cycle, checked before the next edge (R9)
    cur = 1'b1;
    for (int v = 0; v < NV; v++) begin
      if (v == 0 || VEC[v][11] != cur) begin
        cur = VEC[v][11];
        drive(2'b11, 3'b111, 3'b000, 1'b1);
        load_cfg(cur ? CFG_SPLIT : CFG_AND6, v != 0);
      end
      @(negedge clk);
      drive(VEC[v][10:9], VEC[v][8:6], VEC[v][5:3], VEC[v][2]);
      #2;
      check(cur ? "R6 R8 split out0" : "R4 single out0", out0, VEC[v][1]);
      check(cur ? "R7 R8 split out1" : "R5 single out1", out1, VEC[v][0]);
    end

    // R9: change without any clock edge in between
    @(negedge clk);
    drive(2'b00, 3'b000, 3'b000, 1'b0);
    #1;
    check("R9 settle low", out0, 1'b0);
    drive(2'b10, 3'b000, 3'b000, 1'b0);
    #1;
    check("R9 combinational rise", out0, 1'b1);

    // R8: private group of function 1 does not disturb out0
    drive(2'b10, 3'b000, 3'b111, 1'b1);
    #1;
    check("R8 out0 ignores priv1 and top", out0, 1'b1);

    // R2 boundary: mask bit 0 alone in single mode
    load_cfg({1'b0, 64'h1}, 1'b0);
    drive(2'b00, 3'b000, 3'b000, 1'b0);
    #2;
    check("R2 R4 mask bit 0", out0, 1'b1);
    drive(2'b01, 3'b000, 3'b000, 1'b0);
    #2;
    check("R2 R4 mask bit 1 clear", out0, 1'b0);

    // R2 R7 boundary: mask bit 32 alone in split mode
    load_cfg({1'b1, 64'h1_0000_0000}, 1'b0);
    drive(2'b00, 3'b000, 3'b000, 1'b0);
    #2;
    check("R7 mask bit 32 out1", out1, 1'b1);
    check("R6 lower half empty out0", out0, 1'b0);
    // R2: chain holds while cfg_en low over many edges
    cfg_bit = 1'b1;
    repeat (10) @(negedge clk);
    #2;
    check("R2 hold with cfg_en low", out1, 1'b1);

    // R1: reset mid-operation clears the configuration
    load_cfg(CFG_SPLIT, 1'b0);
    drive(2'b01, 3'b000, 3'b000, 1'b0);
    #2;
    check("R6 before reset", out0, 1'b1);
    rst_n = 1'b0;
    #2;
    check("R1 out0 cleared by reset", out0, 1'b0);
    check("R1 out1 cleared by reset", out1, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    drive(2'b11, 3'b111, 3'b111, 1'b1);
    #2;
    check("R1 mask zero after release", out0, 1'b0);
    check("R1 R5 single mode after release", out1, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule